// File: doc/BRIEF.md
# PCI-to-PCI Bridge Forwarding Window Decoder

This block decides whether a transaction seen on the primary side of a PCI-to-PCI bridge should be claimed and passed to the secondary bus. It builds the bounds of the three forwarding windows from the bridge's packed configuration fields. The three windows are an I/O window, a non-prefetchable memory window and a prefetchable memory window. Each bound is assembled from a coarse field, a fill of its low bits that depends on the window's granule, and an optional upper extension. Each window is gated by its command enable. The block also forwards the fixed legacy display ranges while the display-forwarding control bit is set.

A request carries an address and a space flag (I/O or memory) over a valid/ready handshake. The decision comes back one cycle later on a valid/ready response channel. The result is a claim flag and a one-hot vector naming the window that matched. The block holds exactly one result. A new request is accepted when the response register is empty, or when its current result is taken in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no request is accepted. The configuration inputs are sampled in the cycle a request is accepted.

Top module: `pci_window_decode`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_claim` and `rsp_hit` are all zero.
- R2: A request is accepted on a clock edge where `req_valid && req_ready`, and `req_ready` equals `!rsp_valid || rsp_ready`. The result appears with `rsp_valid` high in the next cycle. It stays valid and unchanged until a cycle with `rsp_ready` high.
- R3: I/O window bounds:
  - The low bound is `{up16, io_base[7:4], 12'h000}` and the high bound is `{up16, io_limit[7:4], 12'hFFF}`.
  - `up16` comes from `cfg_io_base_up` / `cfg_io_limit_up` only when `cfg_io_base[3:0] == 4'h1`. Otherwise it is zero.
  - I/O requests compare only address bits 31:0.
- R4: The non-prefetchable memory window spans `{mem_base[15:4], 20'h00000}` to `{mem_limit[15:4], 20'hFFFFF}`. Address bits 63:32 above it are zero.
- R5: Prefetchable window bounds:
  - The bounds are formed like R4 from `cfg_pf_base` / `cfg_pf_limit`.
  - Bits 63:32 come from `cfg_pf_base_up` / `cfg_pf_limit_up` only when `cfg_pf_base[3:0] == 4'h1`. Otherwise they are zero.
- R6: The I/O window claims nothing while `cfg_io_en` is low. Neither memory window claims anything while `cfg_mem_en` is low.
- R7: A window whose high bound is below its low bound claims nothing.
- R8: Legacy display ranges:
  - While `cfg_vga_en` is high, I/O addresses whose bits 15:0 lie in 0x03B0–0x03BB or 0x03C0–0x03DF are claimed, and so are memory addresses 0xA0000–0xBFFFF.
  - These ranges do not depend on the command enables.
  - While `cfg_vga_en` is low, they are not claimed.
- R9: `rsp_hit` is one-hot or zero, and `rsp_claim` equals `rsp_hit != 0`.
  - Bit encoding: bit 0 = I/O window, bit 1 = memory window, bit 2 = prefetchable window, bit 3 = legacy display range.
  - Priority: legacy display range first, then the memory window, then the prefetchable window.
- R10: An I/O request never matches a memory window, and a memory request never matches the I/O window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Transaction address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_io_base | input | 8 | I/O base field, bits 3:0 address-width code |
| cfg_io_limit | input | 8 | I/O limit field |
| cfg_io_base_up | input | IO_W-16 | Upper I/O base bits |
| cfg_io_limit_up | input | IO_W-16 | Upper I/O limit bits |
| cfg_mem_base | input | 16 | Memory base field |
| cfg_mem_limit | input | 16 | Memory limit field |
| cfg_pf_base | input | 16 | Prefetchable base field, bits 3:0 address-width code |
| cfg_pf_limit | input | 16 | Prefetchable limit field |
| cfg_pf_base_up | input | ADDR_W-32 | Upper prefetchable base bits |
| cfg_pf_limit_up | input | ADDR_W-32 | Upper prefetchable limit bits |
| cfg_io_en | input | 1 | Command I/O enable |
| cfg_mem_en | input | 1 | Command memory enable |
| cfg_vga_en | input | 1 | Legacy display forwarding enable |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken when valid |
| rsp_claim | output | 1 | Transaction is forwarded |
| rsp_hit | output | 4 | One-hot matched window |

## Verification
The bench aims at window edges. The first and last byte of each window must claim, and the bytes just outside must not. A design that forgot the 4 KB or 1 MB low-bit fill would drop the top of every window. A design that read the wrong address-width code would place 32-bit I/O or 64-bit prefetchable windows at the wrong base, or would let stale upper registers move a narrow window. Configurations with the limit below the base must claim nothing; a decoder without the empty check would claim everything between the two values or wrap around. Overlaps between the display range and the memory windows, and between the memory and prefetchable windows, check the priority order. Random back-pressure checks that a held result never changes and that no request slips in while the response register is full.

// File: rtl/pciwd_pkg.sv
package pciwd_pkg;
  localparam int ADDR_W_DEF = 64;
  localparam int IO_W_DEF   = 32;
  localparam int NWIN       = 3;
  localparam int HIT_W      = 4;
  localparam int W_IO       = 0;
  localparam int W_MEM      = 1;
  localparam int W_PREF     = 2;
  localparam int H_VGA      = 3;
  localparam int IO_GRAN    = 12;
  localparam int MEM_GRAN   = 20;
  localparam logic [3:0] WIDE_CODE = 4'h1;
  localparam logic [15:0] VGA_IO_A_LO = 16'h03B0;
  localparam logic [15:0] VGA_IO_A_HI = 16'h03BB;
  localparam logic [15:0] VGA_IO_B_LO = 16'h03C0;
  localparam logic [15:0] VGA_IO_B_HI = 16'h03DF;
  localparam logic [31:0] VGA_MEM_LO  = 32'h000A_0000;
  localparam logic [31:0] VGA_MEM_HI  = 32'h000B_FFFF;
endpackage

// File: rtl/pciwd_bounds.sv
module pciwd_bounds
  import pciwd_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int IO_W   = IO_W_DEF
) (
  input  logic [7:0]                       io_base,
  input  logic [7:0]                       io_limit,
  input  logic [IO_W-17:0]                 io_base_up,
  input  logic [IO_W-17:0]                 io_limit_up,
  input  logic [15:0]                      mem_base,
  input  logic [15:0]                      mem_limit,
  input  logic [15:0]                      pf_base,
  input  logic [15:0]                      pf_limit,
  input  logic [ADDR_W-33:0]               pf_base_up,
  input  logic [ADDR_W-33:0]               pf_limit_up,
  input  logic                             io_en,
  input  logic                             mem_en,
  output logic [NWIN-1:0][ADDR_W-1:0]      win_lo,
  output logic [NWIN-1:0][ADDR_W-1:0]      win_hi,
  output logic [NWIN-1:0]                  win_on
);
  localparam int IO_UP_W = IO_W - 16;
  localparam int PF_UP_W = ADDR_W - 32;

  logic              io_wide, pf_wide;
  logic [IO_W-1:0]   io_lo, io_hi;
  logic [31:0]       m_lo, m_hi;
  logic [ADDR_W-1:0] p_lo, p_hi;

  always_comb begin
    io_wide = (io_base[3:0] == WIDE_CODE);
    pf_wide = (pf_base[3:0] == WIDE_CODE);

    io_lo = {(io_wide ? io_base_up  : {IO_UP_W{1'b0}}), io_base[7:4],  {IO_GRAN{1'b0}}};
    io_hi = {(io_wide ? io_limit_up : {IO_UP_W{1'b0}}), io_limit[7:4], {IO_GRAN{1'b1}}};

    m_lo = {mem_base[15:4],  {MEM_GRAN{1'b0}}};
    m_hi = {mem_limit[15:4], {MEM_GRAN{1'b1}}};

    p_lo = {(pf_wide ? pf_base_up  : {PF_UP_W{1'b0}}), pf_base[15:4],  {MEM_GRAN{1'b0}}};
    p_hi = {(pf_wide ? pf_limit_up : {PF_UP_W{1'b0}}), pf_limit[15:4], {MEM_GRAN{1'b1}}};

    win_lo[W_IO]   = {{(ADDR_W-IO_W){1'b0}}, io_lo};
    win_hi[W_IO]   = {{(ADDR_W-IO_W){1'b0}}, io_hi};
    win_lo[W_MEM]  = {{(ADDR_W-32){1'b0}}, m_lo};
    win_hi[W_MEM]  = {{(ADDR_W-32){1'b0}}, m_hi};
    win_lo[W_PREF] = p_lo;
    win_hi[W_PREF] = p_hi;

    win_on[W_IO]   = io_en  && (io_lo <= io_hi);
    win_on[W_MEM]  = mem_en && (m_lo  <= m_hi);
    win_on[W_PREF] = mem_en && (p_lo  <= p_hi);
  end
endmodule

// File: rtl/pciwd_range.sv
module pciwd_range #(
  parameter int W = 64
) (
  input  logic [W-1:0] addr,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         on,
  output logic         hit
);
  assign hit = on && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/pciwd_legacy.sv
module pciwd_legacy
  import pciwd_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_io,
  input  logic              vga_en,
  output logic              hit
);
  logic [15:0] port;
  logic        io_hit, mem_hit;

  always_comb begin
    port    = addr[15:0];
    io_hit  = ((port >= VGA_IO_A_LO) && (port <= VGA_IO_A_HI)) ||
              ((port >= VGA_IO_B_LO) && (port <= VGA_IO_B_HI));
    mem_hit = (addr >= ADDR_W'(VGA_MEM_LO)) && (addr <= ADDR_W'(VGA_MEM_HI));
    hit     = vga_en && (is_io ? io_hit : mem_hit);
  end
endmodule

// File: rtl/pci_window_decode.sv
module pci_window_decode
  import pciwd_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int IO_W   = IO_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_io,
  input  logic [7:0]          cfg_io_base,
  input  logic [7:0]          cfg_io_limit,
  input  logic [IO_W-17:0]    cfg_io_base_up,
  input  logic [IO_W-17:0]    cfg_io_limit_up,
  input  logic [15:0]         cfg_mem_base,
  input  logic [15:0]         cfg_mem_limit,
  input  logic [15:0]         cfg_pf_base,
  input  logic [15:0]         cfg_pf_limit,
  input  logic [ADDR_W-33:0]  cfg_pf_base_up,
  input  logic [ADDR_W-33:0]  cfg_pf_limit_up,
  input  logic                cfg_io_en,
  input  logic                cfg_mem_en,
  input  logic                cfg_vga_en,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_claim,
  output logic [HIT_W-1:0]    rsp_hit
);
  logic [NWIN-1:0][ADDR_W-1:0] win_lo, win_hi;
  logic [NWIN-1:0]             win_on;
  logic [NWIN-1:0]             win_hit;
  logic [ADDR_W-1:0]           io_addr;
  logic                        vga_hit;
  logic [HIT_W-1:0]            hit_nx;
  logic                        accept;

  assign io_addr = {{(ADDR_W-IO_W){1'b0}}, req_addr[IO_W-1:0]};

  pciwd_bounds #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_bounds (
    .io_base     (cfg_io_base),
    .io_limit    (cfg_io_limit),
    .io_base_up  (cfg_io_base_up),
    .io_limit_up (cfg_io_limit_up),
    .mem_base    (cfg_mem_base),
    .mem_limit   (cfg_mem_limit),
    .pf_base     (cfg_pf_base),
    .pf_limit    (cfg_pf_limit),
    .pf_base_up  (cfg_pf_base_up),
    .pf_limit_up (cfg_pf_limit_up),
    .io_en       (cfg_io_en),
    .mem_en      (cfg_mem_en),
    .win_lo      (win_lo),
    .win_hi      (win_hi),
    .win_on      (win_on)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pciwd_range #(.W(ADDR_W)) u_rng (
      .addr ((g == W_IO) ? io_addr : req_addr),
      .lo   (win_lo[g]),
      .hi   (win_hi[g]),
      .on   (win_on[g]),
      .hit  (win_hit[g])
    );
  end

  pciwd_legacy #(.ADDR_W(ADDR_W)) u_legacy (
    .addr   (req_addr),
    .is_io  (req_io),
    .vga_en (cfg_vga_en),
    .hit    (vga_hit)
  );

  // Priority: legacy display, then I/O (io space) or memory, then prefetchable
  always_comb begin
    hit_nx = '0;
    if (vga_hit)                    hit_nx[H_VGA]  = 1'b1;
    else if (req_io)                hit_nx[W_IO]   = win_hit[W_IO];
    else if (win_hit[W_MEM])        hit_nx[W_MEM]  = 1'b1;
    else if (win_hit[W_PREF])       hit_nx[W_PREF] = 1'b1;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_hit   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_claim <= |hit_nx;
      rsp_hit   <= hit_nx;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_hit));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_claim)));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_empty_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit[W_MEM]) |-> (cfg_mem_limit[15:4] >= cfg_mem_base[15:4]));

  assert_gate_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_hit[W_IO]) |-> cfg_io_en);

  assert_gate_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (win_hit[W_MEM] || win_hit[W_PREF])) |-> cfg_mem_en);
endmodule

// File: tb/pci_window_decode_bench.sv
module pci_window_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic [7:0]  cfg_io_base = '0, cfg_io_limit = '0;
  logic [15:0] cfg_io_base_up = '0, cfg_io_limit_up = '0;
  logic [15:0] cfg_mem_base = '0, cfg_mem_limit = '0, cfg_pf_base = '0, cfg_pf_limit = '0;
  logic [31:0] cfg_pf_base_up = '0, cfg_pf_limit_up = '0;
  logic        cfg_io_en = 1'b0, cfg_mem_en = 1'b0, cfg_vga_en = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_claim;
  logic [3:0]  rsp_hit;

  // staged configuration, copied to the pins at the driving edge
  logic [7:0]  s_iob, s_iol;
  logic [15:0] s_iobh, s_iolh, s_mb, s_ml, s_pb, s_pl;
  logic [31:0] s_pbh, s_plh;
  logic        s_ioen, s_memen, s_vga;

  typedef struct {
    logic [3:0] hit;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  bp_en = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  pci_window_decode u_pci_window_decode (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_io,
    .cfg_io_base, .cfg_io_limit, .cfg_io_base_up, .cfg_io_limit_up,
    .cfg_mem_base, .cfg_mem_limit, .cfg_pf_base, .cfg_pf_limit,
    .cfg_pf_base_up, .cfg_pf_limit_up, .cfg_io_en, .cfg_mem_en, .cfg_vga_en,
    .rsp_valid, .rsp_ready, .rsp_claim, .rsp_hit
  );

  // bounds from the requirement text (R3, R4, R5)
  function automatic void bnd(input int w, output logic [63:0] lo, output logic [63:0] hi);
    logic [15:0] iu_b, iu_l;
    logic [31:0] pu_b, pu_l;
    iu_b = (s_iob[3:0] == 4'h1) ? s_iobh : 16'h0;
    iu_l = (s_iob[3:0] == 4'h1) ? s_iolh : 16'h0;
    pu_b = (s_pb[3:0] == 4'h1) ? s_pbh : 32'h0;
    pu_l = (s_pb[3:0] == 4'h1) ? s_plh : 32'h0;
    case (w)
      0: begin lo = {32'h0, iu_b, s_iob[7:4], 12'h000}; hi = {32'h0, iu_l, s_iol[7:4], 12'hFFF}; end
      1: begin lo = {32'h0, s_mb[15:4], 20'h00000}; hi = {32'h0, s_ml[15:4], 20'hFFFFF}; end
      default: begin lo = {pu_b, s_pb[15:4], 20'h00000}; hi = {pu_l, s_pl[15:4], 20'hFFFFF}; end
    endcase
  endfunction

  function automatic logic [3:0] ref_hit(input logic [63:0] a, input logic io);
    logic [63:0] lo, hi, a32;
    int unsigned p;
    p = a[15:0];
    if (io) begin
      if (s_vga && ((p >= 'h3B0 && p <= 'h3BB) || (p >= 'h3C0 && p <= 'h3DF))) return 4'b1000;
      a32 = {32'h0, a[31:0]};
      bnd(0, lo, hi);
      if (s_ioen && lo <= hi && a32 >= lo && a32 <= hi) return 4'b0001;
      return 4'b0000;
    end
    if (s_vga && a >= 64'hA0000 && a <= 64'hBFFFF) return 4'b1000;
    bnd(1, lo, hi);
    if (s_memen && lo <= hi && a >= lo && a <= hi) return 4'b0010;
    bnd(2, lo, hi);
    if (s_memen && lo <= hi && a >= lo && a <= hi) return 4'b0100;
    return 4'b0000;
  endfunction

  function automatic string tag_of(input logic [3:0] h);
    case (h)
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0100: return "R5";
      4'b1000: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // observe the settled outputs after the driving edge
  task automatic observe(input string tag, input logic [3:0] eh, input bit push_ok);
    exp_t e;
    chk(req_ready == (!rsp_valid || rsp_ready), "R2", "req_ready", req_ready, !rsp_valid || rsp_ready);
    if (rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected rsp_valid", rsp_valid, 0);
      else if (rsp_ready) begin
        e = exp_q.pop_front();
        chk(rsp_hit === e.hit, e.tag, "rsp_hit", rsp_hit, e.hit);
        chk(rsp_claim === (e.hit != 0), "R9", "rsp_claim", rsp_claim, e.hit != 0);
      end
    end
    if (push_ok && req_valid && req_ready) begin
      e.hit = eh;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drive_pins();
    cfg_io_base = s_iob; cfg_io_limit = s_iol; cfg_io_base_up = s_iobh; cfg_io_limit_up = s_iolh;
    cfg_mem_base = s_mb; cfg_mem_limit = s_ml; cfg_pf_base = s_pb; cfg_pf_limit = s_pl;
    cfg_pf_base_up = s_pbh; cfg_pf_limit_up = s_plh;
    cfg_io_en = s_ioen; cfg_mem_en = s_memen; cfg_vga_en = s_vga;
  endtask

  task automatic send(input logic [63:0] a, input logic io, input string tag);
    bit acc;
    logic [3:0] eh;
    string t;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      drive_pins();
      req_valid = 1'b1;
      req_addr  = a;
      req_io    = io;
      rsp_ready = bp_en ? ($urandom % 4 != 0) : 1'b1;
      #1;
      eh = ref_hit(a, io);
      t  = (tag == "") ? tag_of(eh) : tag;
      acc = req_ready;
      observe(t, eh, 1'b1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      rsp_ready = 1'b1;
      #1;
      observe("", 4'b0, 1'b0);
    end
  endtask

  task automatic cfg_default();
    s_iob = 8'h00; s_iol = 8'h00; s_iobh = 16'h0; s_iolh = 16'h0;
    s_mb = 16'hFFF0; s_ml = 16'h0000; s_pb = 16'hFFF0; s_pl = 16'h0000;
    s_pbh = 32'h0; s_plh = 32'h0;
    s_ioen = 1'b1; s_memen = 1'b1; s_vga = 1'b0;
  endtask

  function automatic logic [7:0] nib_step(input logic [7:0] f, input int d);
    int v;
    v = int'(f[7:4]) + d;
    if (v < 0) v = 0;
    if (v > 15) v = 15;
    return {4'(v), f[3:0]};
  endfunction

  initial begin
    cfg_default();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    chk(rsp_valid == 1'b0 && rsp_claim == 1'b0 && rsp_hit == 4'b0, "R1", "reset outputs",
        {rsp_valid, rsp_claim, rsp_hit}, 0);

    // R3: 16-bit I/O window 0x2000..0x3FFF
    s_iob = 8'h20; s_iol = 8'h30;
    send(64'h2000, 1'b1, "R3"); send(64'h3FFF, 1'b1, "R3");
    send(64'h4000, 1'b1, "R3"); send(64'h1FFF, 1'b1, "R3");
    send(64'hFFFF_FFFF_0000_3000, 1'b1, "R3");
    s_iobh = 16'h7; s_iolh = 16'h7;   // ignored while narrow
    send(64'h2800, 1'b1, "R3");
    // R3: 32-bit I/O window
    s_iob = 8'h21; s_iol = 8'h21; s_iobh = 16'h0001; s_iolh = 16'h0002;
    send(64'h0001_2000, 1'b1, "R3"); send(64'h0002_2FFF, 1'b1, "R3");
    send(64'h0000_2000, 1'b1, "R3"); send(64'h0002_3000, 1'b1, "R3");
    cfg_default();

    // R4: memory window 0x1000_0000..0x101F_FFFF
    s_mb = 16'h1000; s_ml = 16'h1010;
    send(64'h1000_0000, 1'b0, "R4"); send(64'h101F_FFFF, 1'b0, "R4");
    send(64'h1020_0000, 1'b0, "R4"); send(64'h0FFF_FFFF, 1'b0, "R4");
    send(64'h1_1000_0000, 1'b0, "R4");
    // R10: space type separates windows
    s_iob = 8'h10; s_iol = 8'h10;
    send(64'h1000_0000, 1'b1, "R10"); send(64'h1000, 1'b0, "R10");
    cfg_default();

    // R5: 64-bit prefetchable window
    s_pb = 16'h2001; s_pl = 16'h2001; s_pbh = 32'h1; s_plh = 32'h1;
    send(64'h1_2000_0000, 1'b0, "R5"); send(64'h1_200F_FFFF, 1'b0, "R5");
    send(64'h2000_0000, 1'b0, "R5"); send(64'h1_2010_0000, 1'b0, "R5");
    s_pb = 16'h3000; s_pl = 16'h3000; s_pbh = 32'h5; s_plh = 32'h5;
    send(64'h3000_0000, 1'b0, "R5"); send(64'h5_3000_0000, 1'b0, "R5");
    cfg_default();

    // R6: command enables
    s_iob = 8'h20; s_iol = 8'h20; s_mb = 16'h1000; s_ml = 16'h1000; s_pb = 16'h2000; s_pl = 16'h2000;
    s_ioen = 1'b0;
    send(64'h2000, 1'b1, "R6"); send(64'h1000_0000, 1'b0, "R6");
    s_ioen = 1'b1; s_memen = 1'b0;
    send(64'h2000, 1'b1, "R6"); send(64'h1000_0000, 1'b0, "R6"); send(64'h2000_0000, 1'b0, "R6");
    cfg_default();

    // R7: limit below base
    s_iob = 8'h50; s_iol = 8'h40; s_mb = 16'h2000; s_ml = 16'h1FF0; s_pb = 16'h4001; s_pl = 16'h4001;
    s_pbh = 32'h2; s_plh = 32'h1;
    send(64'h4800, 1'b1, "R7"); send(64'h5000, 1'b1, "R7");
    send(64'h2000_0000, 1'b0, "R7"); send(64'h1FF0_0000, 1'b0, "R7");
    send(64'h1_4000_0000, 1'b0, "R7"); send(64'h2_4000_0000, 1'b0, "R7");
    cfg_default();

    // R8: legacy display ranges
    s_vga = 1'b1; s_ioen = 1'b0; s_memen = 1'b0;
    send(64'h3B0, 1'b1, "R8"); send(64'h3BB, 1'b1, "R8"); send(64'h3BC, 1'b1, "R8");
    send(64'h3BF, 1'b1, "R8"); send(64'h3C0, 1'b1, "R8");
    send(64'h3DF, 1'b1, "R8"); send(64'h3E0, 1'b1, "R8"); send(64'h1_03C0, 1'b1, "R8");
    send(64'hA0000, 1'b0, "R8"); send(64'hBFFFF, 1'b0, "R8"); send(64'hC0000, 1'b0, "R8");
    send(64'h9FFFF, 1'b0, "R8"); send(64'hA0000, 1'b1, "R8"); send(64'h3C0, 1'b0, "R8");
    s_vga = 1'b0;
    send(64'hA0000, 1'b0, "R8"); send(64'h3C0, 1'b1, "R8");
    cfg_default();

    // R9: priority among overlapping windows
    s_mb = 16'h0000; s_ml = 16'h0000; s_pb = 16'h0000; s_pl = 16'h0010; s_vga = 1'b1;
    s_iob = 8'h00; s_iol = 8'h00;
    send(64'hA0000, 1'b0, "R9"); send(64'h50000, 1'b0, "R9"); send(64'h150000, 1'b0, "R9");
    send(64'h3C4, 1'b1, "R9"); send(64'h100, 1'b1, "R9");
    s_vga = 1'b0;
    send(64'hA0000, 1'b0, "R9");
    cfg_default();

    // R2: back-to-back under random back-pressure
    bp_en = 1'b1;
    s_mb = 16'h1000; s_ml = 16'h1000;
    for (int i = 0; i < 40; i++) send(64'h1000_0000 + 64'(i) * 64'h8000, 1'b0, "R2");
    idle(4);

    // random phase: tag by expected window
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] lo, hi, a;
      int w;
      logic io;
      if (i % 8 == 0) begin
        s_iob  = {4'($urandom), ($urandom % 2 == 0) ? 4'h1 : 4'h0};
        s_iol  = nib_step(s_iob, int'($urandom % 8) - 2);
        s_iobh = 16'($urandom % 4); s_iolh = s_iobh + 16'($urandom % 3) - 16'd1;
        s_mb   = {12'($urandom), 4'h0};
        s_ml   = {s_mb[15:4] + 12'($urandom % 8) - 12'd2, 4'h0};
        s_pb   = {12'($urandom), ($urandom % 2 == 0) ? 4'h1 : 4'h0};
        s_pl   = {s_pb[15:4] + 12'($urandom % 8) - 12'd2, s_pb[3:0]};
        s_pbh  = 32'($urandom % 4); s_plh = s_pbh + 32'($urandom % 3) - 32'd1;
        s_ioen = ($urandom % 5 != 0); s_memen = ($urandom % 5 != 0); s_vga = ($urandom % 2 == 0);
      end
      w  = int'($urandom % 3);
      io = (w == 0) ? ($urandom % 6 != 0) : ($urandom % 6 == 0);
      bnd(w, lo, hi);
      case ($urandom % 8)
        0: a = lo;
        1: a = hi;
        2: a = lo - 64'd1;
        3: a = hi + 64'd1;
        4: a = lo + 64'($urandom % 4096);
        5: a = io ? 64'($urandom % 'h40) + 64'h3A8 : 64'hA0000 + 64'($urandom % 'h20000) - 64'h10;
        default: a = {$urandom, $urandom};
      endcase
      send(a, io, "");
    end
    idle(6);
    chk(exp_q.size() == 0, "R2", "undelivered results", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule